// File: doc/BRIEF.md
# Serial ADC Dual-Word Frame Reader

This block is an SPI master that reads one conversion frame from an external serial converter. A single-cycle start request pulls the active-low chip select down. The block then generates a serial clock at a rate set by a divider input and shifts in 32 bits from the converter's data line. The outgoing data line only carries zeros, because its sole purpose is to produce the clocks the read needs.

The 32 bits go out as one continuous burst. Chip select stays low and no pause is inserted between the two 16-bit words. Each word is split into a 4-bit status field, taken from its upper bits, and a 12-bit sample field. The four decoded fields update together at the end of the frame. In that same cycle a one-cycle valid pulse fires and a sticky done flag is set. A guard interval follows each frame, and a start request that arrives while a frame or its guard interval is in progress is ignored.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, csN is 1, sclk is 0, busy, frameValid and done are 0, and all four field outputs are 0.
- R2: A start pulse while busy is 0 drives csN to 0 and busy to 1 on the next clock edge. csN then stays low, without interruption, for exactly 32 rising sclk edges.
- R3: Every sclk half-period during a frame lasts DIV+1 system clock cycles, where DIV is the value of div captured when the start is accepted. This includes the delay from the csN fall to the first rising edge. A change on div during a frame has no effect on that frame.
- R4: mosi is 0 at all times.
- R5: miso is sampled on each rising sclk edge, MSB first. Received bits 31..28 appear on status0, bits 27..16 on data0, bits 15..12 on status1 and bits 11..0 on data1, where bit 31 is the first bit received.
- R6: csN rises exactly DIV+1 system clock cycles after the final falling sclk edge, and sclk is 0 whenever csN is 1.
- R7: frameValid is a one-cycle pulse in the cycle in which csN returns high. The field outputs take their new values in that same cycle and hold them until the next frame ends.
- R8: done is set together with frameValid and cleared when the next start is accepted.
- R9: A start pulse while busy is 1 is ignored. This holds both in mid-frame and in the cycle of frameValid. Such a pulse neither shortens nor extends the running frame, and it starts no second frame.
- R10: busy returns to 0 DIV+1 system clock cycles after the cycle of frameValid, so csN stays high for at least one half-period between frames.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle frame request |
| div | input | DIV_W (8) | Half-period divider; half-period is div+1 clocks |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter, always zero |
| busy | output | 1 | Frame or guard interval in progress |
| frameValid | output | 1 | One-cycle pulse when a frame completes |
| done | output | 1 | Sticky completion flag, cleared by an accepted start |
| status0 | output | STAT_BITS (4) | Status field of the first word |
| data0 | output | WORD_BITS-STAT_BITS (12) | Sample field of the first word |
| status1 | output | STAT_BITS (4) | Status field of the second word |
| data1 | output | WORD_BITS-STAT_BITS (12) | Sample field of the second word |

## Verification
The close of a frame and a new start request can land in the same cycle. When that happens, the commit of the decoded fields must win and the request must be dropped. The bench provokes this by raising start in the exact cycle it sees frameValid, and by raising it again in the middle of a burst. It then judges the result at the pins. It counts that csN falls no extra time, that exactly 32 rising sclk edges and one valid pulse occur, and that busy clears DIV+1 cycles after the valid pulse.

// File: rtl/afr_pkg.sv
package afr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } afrState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;   // start accepted: empty shifter, drop done
    logic shift;   // rising sclk edge: take one miso bit
    logic commit;  // frame closed: publish decoded fields
  } afrStrobe_t;

endpackage

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FRAME_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             csN,
  output logic             busy,
  output afrStrobe_t       strobe
);

  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS);

  afrState_e        stateQ, stateD;
  logic [DIV_W-1:0] divQ, divD;
  logic [DIV_W-1:0] halfCntQ, halfCntD;
  logic [BIT_W-1:0] bitCntQ, bitCntD;
  logic             sclkQ, sclkD;
  logic             csQ, csD;
  logic             tick;

  assign tick = (halfCntQ == '0);

  always_comb begin
    stateD   = stateQ;
    divD     = divQ;
    halfCntD = halfCntQ;
    bitCntD  = bitCntQ;
    sclkD    = sclkQ;
    csD      = csQ;
    strobe   = '0;
    if (stateQ != ST_IDLE) begin
      halfCntD = tick ? divQ : halfCntQ - 1'b1;
    end
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stateD       = ST_LEAD;
          csD          = 1'b0;
          divD         = div;
          halfCntD     = div;
          bitCntD      = '0;
          strobe.clear = 1'b1;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          sclkD        = 1'b1;
          strobe.shift = 1'b1;
          bitCntD      = bitCntQ + 1'b1;
          stateD       = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sclkQ) begin
            sclkD = 1'b0;
            if (bitCntQ == LAST_BIT) stateD = ST_TRAIL;
          end else begin
            sclkD        = 1'b1;
            strobe.shift = 1'b1;
            bitCntD      = bitCntQ + 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          csD           = 1'b1;
          strobe.commit = 1'b1;
          stateD        = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      divQ     <= '0;
      halfCntQ <= '0;
      bitCntQ  <= '0;
      sclkQ    <= 1'b0;
      csQ      <= 1'b1;
    end else begin
      stateQ   <= stateD;
      divQ     <= divD;
      halfCntQ <= halfCntD;
      bitCntQ  <= bitCntD;
      sclkQ    <= sclkD;
      csQ      <= csD;
    end
  end

  assign sclk = sclkQ;
  assign csN  = csQ;
  assign busy = (stateQ != ST_IDLE);

  // R6
  cs_high_sclk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csQ |-> !sclkQ);

  // R2 R9
  cs_fall_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csQ) |-> ($past(start) && $past(stateQ) == ST_IDLE));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && stateQ != ST_GAP) |=> !$rose(csQ) || $past(stateQ) == ST_TRAIL);

  // R3
  sclk_moves_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkQ) |-> (!csQ && !$past(csQ)));

endmodule

// File: rtl/afr_datapath.sv
module afr_datapath
  import afr_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int WORD_BITS  = 16,
  parameter int STAT_BITS  = 4
) (
  input  logic                                           clk,
  input  logic                                           rstN,
  input  afrStrobe_t                                     strobe,
  input  logic                                           miso,
  output logic                                           mosi,
  output logic                                           frameValid,
  output logic                                           done,
  output logic [FRAME_BITS/WORD_BITS-1:0][STAT_BITS-1:0] statusW,
  output logic [FRAME_BITS/WORD_BITS-1:0][WORD_BITS-STAT_BITS-1:0] dataW
);

  localparam int NUM_WORDS = FRAME_BITS / WORD_BITS;
  localparam int DATA_BITS = WORD_BITS - STAT_BITS;

  logic [FRAME_BITS-1:0] shiftQ;
  logic [NUM_WORDS-1:0][STAT_BITS-1:0] statusD;
  logic [NUM_WORDS-1:0][DATA_BITS-1:0] dataD;
  logic                  validQ;
  logic                  doneQ;

  // outgoing line only clocks the read: dummy zeros
  assign mosi = 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strobe.clear) begin
      shiftQ <= '0;
    end else if (strobe.shift) begin
      shiftQ <= {shiftQ[FRAME_BITS-2:0], miso};
    end
  end

  // word 0 is the first one on the wire, held in the upper bits
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int TOP = FRAME_BITS - 1 - w * WORD_BITS;
    logic [WORD_BITS-1:0] word;
    assign word       = shiftQ[TOP -: WORD_BITS];
    assign statusD[w] = word[WORD_BITS-1 -: STAT_BITS];
    assign dataD[w]   = word[DATA_BITS-1:0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusW[w] <= '0;
        dataW[w]   <= '0;
      end else if (strobe.commit) begin
        statusW[w] <= statusD[w];
        dataW[w]   <= dataD[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      validQ <= strobe.commit;
      if (strobe.clear)       doneQ <= 1'b0;
      else if (strobe.commit) doneQ <= 1'b1;
    end
  end

  assign frameValid = validQ;
  assign done       = doneQ;

  // R7
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ);

  // R8
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> doneQ);

  // R7
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> ($stable(statusW) && $stable(dataW)));

  // R5
  shift_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.shift && !strobe.clear) |=> $stable(shiftQ));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import afr_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FRAME_BITS = 32,
  parameter int WORD_BITS  = 16,
  parameter int STAT_BITS  = 4,
  localparam int DATA_BITS = WORD_BITS - STAT_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [DIV_W-1:0]     div,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 csN,
  output logic                 mosi,
  output logic                 busy,
  output logic                 frameValid,
  output logic                 done,
  output logic [STAT_BITS-1:0] status0,
  output logic [DATA_BITS-1:0] data0,
  output logic [STAT_BITS-1:0] status1,
  output logic [DATA_BITS-1:0] data1
);

  localparam int NUM_WORDS = FRAME_BITS / WORD_BITS;

  afrStrobe_t strobe;
  logic [NUM_WORDS-1:0][STAT_BITS-1:0] statusW;
  logic [NUM_WORDS-1:0][DATA_BITS-1:0] dataW;

  afr_ctrl #(
    .DIV_W     (DIV_W),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .div   (div),
    .sclk  (sclk),
    .csN   (csN),
    .busy  (busy),
    .strobe(strobe)
  );

  afr_datapath #(
    .FRAME_BITS(FRAME_BITS),
    .WORD_BITS (WORD_BITS),
    .STAT_BITS (STAT_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .miso      (miso),
    .mosi      (mosi),
    .frameValid(frameValid),
    .done      (done),
    .statusW   (statusW),
    .dataW     (dataW)
  );

  assign status0 = statusW[0];
  assign data0   = dataW[0];
  assign status1 = statusW[NUM_WORDS-1];
  assign data1   = dataW[NUM_WORDS-1];

endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  div = 8'd0;
  logic        miso = 1'b0;
  logic        sclk, csN, mosi, busy, frameValid, done;
  logic [3:0]  status0, status1;
  logic [11:0] data0, data1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_frame_reader u_adc_frame_reader (
    .clk(clk), .rstN(rstN), .start(start), .div(div), .miso(miso),
    .sclk(sclk), .csN(csN), .mosi(mosi), .busy(busy),
    .frameValid(frameValid), .done(done),
    .status0(status0), .data0(data0), .status1(status1), .data1(data1)
  );

  // converter model: first bit on csN fall, next bit on each falling sclk
  logic [31:0] slaveWord = '0;
  int idx;
  initial begin
    forever begin
      @(negedge csN);
      idx  = 31;
      miso = slaveWord[31];
      while (!csN) begin
        @(negedge sclk or posedge csN);
        if (!csN && idx > 0) begin
          idx--;
          miso = slaveWord[idx];
        end
      end
    end
  end

  // pin monitor, sampled on the falling system clock edge
  int cyc = 0, lastEdge = 0, riseCnt = 0, minH = 0, maxH = 0, trailH = 0;
  int csFalls = 0, validCnt = 0, mosiHigh = 0;
  logic prevSclk = 1'b0, prevCs = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevCs && !csN) begin
        lastEdge = cyc; riseCnt = 0; minH = 1000000; maxH = 0; csFalls++;
      end
      if (!csN && sclk != prevSclk) begin
        if (cyc - lastEdge < minH) minH = cyc - lastEdge;
        if (cyc - lastEdge > maxH) maxH = cyc - lastEdge;
        lastEdge = cyc;
        if (sclk) riseCnt++;
      end
      if (!prevCs && csN) trailH = cyc - lastEdge;
      if (frameValid) validCnt++;
      if (mosi) mosiHigh++;
    end
    prevSclk = sclk;
    prevCs   = csN;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) step();
    // R1 reset state
    check("R1", "csN", csN, 1);
    check("R1", "sclk", sclk, 0);
    check("R1", "busy", busy, 0);
    check("R1", "frameValid", frameValid, 0);
    check("R1", "done", done, 0);
    check("R1", "fields", {status0, data0, status1, data1}, 0);
    rstN = 1'b1;
    repeat (2) step();
    check("R1", "csN after release", csN, 1);
  endtask

  // mode 0 plain, 1 start mid-frame, 2 div change mid-frame, 3 start in commit cycle
  task automatic t_frame(int divv, logic [31:0] word, int mode);
    int n;
    int baseValid, baseFalls;
    slaveWord = word;
    div = 8'(divv);
    baseValid = validCnt;
    start = 1'b1;
    step();
    start = 1'b0;
    // R2 accepted start
    check("R2", "csN low after start", csN, 0);
    check("R2", "busy after start", busy, 1);
    // R8 cleared by accepted start
    check("R8", "done cleared", done, 0);
    baseFalls = csFalls;
    if (mode == 1) begin
      repeat (10 * (divv + 1)) step();
      start = 1'b1;
      step();
      start = 1'b0;
    end
    if (mode == 2) begin
      repeat (7 * (divv + 1)) step();
      div = 8'(divv + 4);
    end
    n = 0;
    while (!frameValid && n < 100 * (divv + 1) + 100) begin
      step();
      n++;
    end
    check("R7", "frameValid seen", frameValid, 1);
    check("R7", "csN high with valid", csN, 1);
    // R5 field placement
    check("R5", "status0", status0, int'(word[31:28]));
    check("R5", "data0", data0, int'(word[27:16]));
    check("R5", "status1", status1, int'(word[15:12]));
    check("R5", "data1", data1, int'(word[11:0]));
    check("R2", "rising sclk edges", riseCnt, 32);
    // R3 half-period, incl. after a div change
    check("R3", "min half-period", minH, divv + 1);
    check("R3", "max half-period", maxH, divv + 1);
    check("R6", "trail before csN rise", trailH, divv + 1);
    check("R8", "done with valid", done, 1);
    if (mode == 3) start = 1'b1;
    step();
    start = 1'b0;
    check("R7", "valid one cycle", frameValid, 0);
    n = 1;
    while (busy && n < 1000) begin
      step();
      n++;
    end
    // R10 guard interval
    check("R10", "busy drop delay", n, divv + 1);
    repeat (3 * (divv + 1) + 4) step();
    // R9 no extra frame
    check("R9", "no extra csN fall", csFalls - baseFalls, 0);
    check("R9", "one valid pulse", validCnt - baseValid, 1);
    check("R7", "fields hold", {status0, data0, status1, data1}, {word[31:28], word[27:16], word[15:12], word[11:0]});
    check("R4", "mosi never high", mosiHigh, 0);
    div = 8'd0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame(0, 32'hA5C3_3CF0, 0);
    t_frame(1, 32'h8001_7FFE, 0);
    t_frame(3, 32'hFFFF_0000, 0);
    t_frame(2, 32'h1234_ABCD, 1);
    t_frame(2, 32'h0F0F_F0F0, 2);
    t_frame(1, 32'h6E95_0001, 3);
    t_frame(0, 32'h0000_0000, 3);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule